// File: doc/BRIEF.md
# Ratiometric Interface Clock Frequency Meter

This block measures how fast an interface clock runs compared with a reference clock, which is normally the processor clock. It counts interface-clock cycles over a window whose length is a fixed power of two of reference cycles. It scales that count so the result reads as an unsigned fixed-point ratio with sixteen fraction bits. With the default 65536-cycle window the count is already in 16.16 form: a value of 0x0001_0000 means both clocks run at the same rate. With a 100 MHz reference, one LSB is close to 1.5 kHz and the full range reaches about 6.55 THz.

Window boundaries pass from the reference domain into the interface domain as a toggle. The interface side keeps a free-running, saturating cycle counter. At each boundary it freezes the count in a snapshot register and returns a toggle. When that toggle arrives back in the reference domain, the reference side captures the stable snapshot. A second output gives a constant clock-ratio word, set by a parameter. Software multiplies the measured ratio by this word to recover the true interface clock.

Top module: `clk_ratio_meter`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `freq_ratio` reads 0.
- R2: Window boundaries are spaced exactly 2^WIN_LOG2 reference cycles apart, measured from the release of reset.
- R3: After the interface clock has been steady for at least two whole windows, `freq_ratio` equals (interface cycles per window) << (16 - WIN_LOG2), within two counts of the ideal value Tref * 2^WIN_LOG2 / Tif.
- R4: The interface-side count saturates at all ones and never wraps. When the count is saturated, `freq_ratio` reads all ones across its full width.
- R5: `freq_ratio` changes only in the cycle after a completed window's count arrives. It holds between arrivals. If the interface clock stops, `freq_ratio` keeps its last value.
- R6: The partial window that ends at the first boundary after reset is never reported. `freq_ratio` stays 0 until the second boundary's count arrives.
- R7: `clk_ratio` always equals the CLK_RATIO parameter, including during reset.
- R8: After the interface clock stops and then restarts at a new rate, the measurement recovers to the new rate within three windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (processor) clock |
| if_clk | input | 1 | Interface clock being measured |
| rst_n | input | 1 | Active-low reset, asynchronous assert; released in step with ref_clk |
| freq_ratio | output | RES_W (32) | Measured frequency ratio, 16 fraction bits |
| clk_ratio | output | 32 | Constant interface clock ratio word |

## Verification
The hardest situations to reach are a stopped interface clock, and a restart after the stop. While the clock is stopped, the synchronizer misses boundaries and the first window after the restart is corrupt. The bench gates the interface clock off in the middle of a run. It then confirms the result stays frozen for several windows, restarts the clock at a new rate, and checks recovery. A shortened window and a narrowed integer field let the bench reach saturation with a realistic fast interface clock. Random clock periods from a fixed seed cover ratios both above and below one.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int FRAC_W = 16;

  function automatic int res_width(input int int_w);
    return int_w + FRAC_W;
  endfunction

  function automatic int scale_shift(input int win_log2);
    return FRAC_W - win_log2;
  endfunction
endpackage

// File: rtl/fm_toggle_sync.sv
module fm_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], tog_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/fm_ref_window.sv
module fm_ref_window #(
  parameter int WIN_LOG2 = 16
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  output logic                win_tog,
  output logic [WIN_LOG2-1:0] win_cnt
);
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      win_tog <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (&win_cnt) win_tog <= ~win_tog;
    end
  end
endmodule

// File: rtl/fm_if_counter.sv
module fm_if_counter #(
  parameter int CNT_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             if_clk,
  input  logic             rst_n,
  input  logic             win_tog,
  output logic             if_rst_n,
  output logic             if_bnd,
  output logic [CNT_W-1:0] if_cnt,
  output logic [CNT_W-1:0] snap,
  output logic             ack_tog
);
  logic [1:0] rst_sync;
  logic       primed;

  always_ff @(posedge if_clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign if_rst_n = rst_sync[1];

  fm_toggle_sync #(.STAGES(STAGES)) u_bnd_sync (
    .clk    (if_clk),
    .rst_n  (if_rst_n),
    .tog_in (win_tog),
    .pulse  (if_bnd)
  );

  always_ff @(posedge if_clk or negedge if_rst_n) begin
    if (!if_rst_n) begin
      if_cnt  <= '0;
      snap    <= '0;
      ack_tog <= 1'b0;
      primed  <= 1'b0;
    end else if (if_bnd) begin
      if_cnt <= CNT_W'(1);
      primed <= 1'b1;
      if (primed) begin
        snap    <= if_cnt;
        ack_tog <= ~ack_tog;
      end
    end else if (!(&if_cnt)) begin
      if_cnt <= if_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fm_ref_capture.sv
module fm_ref_capture #(
  parameter int CNT_W  = 32,
  parameter int RES_W  = 32,
  parameter int SHIFT  = 0,
  parameter int STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             ack_tog,
  input  logic [CNT_W-1:0] snap,
  output logic             upd_pulse,
  output logic [RES_W-1:0] freq_ratio
);
  fm_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .tog_in (ack_tog),
    .pulse  (upd_pulse)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)         freq_ratio <= '0;
    else if (upd_pulse) freq_ratio <= (&snap) ? '1 : (RES_W'(snap) << SHIFT);
  end
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter #(
  parameter int          WIN_LOG2    = 16,
  parameter int          INT_W       = 16,
  parameter logic [31:0] CLK_RATIO   = 32'd1,
  parameter int          SYNC_STAGES = 2,
  localparam int         RES_W       = fm_pkg::res_width(INT_W),
  localparam int         SHIFT       = fm_pkg::scale_shift(WIN_LOG2),
  localparam int         CNT_W       = RES_W - SHIFT
) (
  input  logic             ref_clk,
  input  logic             if_clk,
  input  logic             rst_n,
  output logic [RES_W-1:0] freq_ratio,
  output logic [31:0]      clk_ratio
);
  logic                win_tog;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                if_rst_n;
  logic                if_bnd;
  logic [CNT_W-1:0]    if_cnt;
  logic [CNT_W-1:0]    snap;
  logic                ack_tog;
  logic                upd_pulse;

  fm_ref_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .win_tog (win_tog),
    .win_cnt (win_cnt)
  );

  fm_if_counter #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_count (
    .if_clk   (if_clk),
    .rst_n    (rst_n),
    .win_tog  (win_tog),
    .if_rst_n (if_rst_n),
    .if_bnd   (if_bnd),
    .if_cnt   (if_cnt),
    .snap     (snap),
    .ack_tog  (ack_tog)
  );

  fm_ref_capture #(.CNT_W(CNT_W), .RES_W(RES_W), .SHIFT(SHIFT), .STAGES(SYNC_STAGES)) u_capture (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .ack_tog    (ack_tog),
    .snap       (snap),
    .upd_pulse  (upd_pulse),
    .freq_ratio (freq_ratio)
  );

  assign clk_ratio = CLK_RATIO;
endmodule

// File: rtl/clk_ratio_meter_chk.sv
module clk_ratio_meter_chk #(
  parameter int RES_W    = 32,
  parameter int CNT_W    = 32,
  parameter int WIN_LOG2 = 16
) (
  input logic                ref_clk,
  input logic                if_clk,
  input logic                rst_n,
  input logic                if_rst_n,
  input logic [RES_W-1:0]    freq_ratio,
  input logic                upd_pulse,
  input logic                win_tog,
  input logic [WIN_LOG2-1:0] win_cnt,
  input logic [CNT_W-1:0]    if_cnt,
  input logic                if_bnd
);
  AST_RESET_ZERO: assert property (@(posedge ref_clk) $rose(rst_n) |-> freq_ratio == '0); // R1

  AST_WINDOW_EDGE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(win_tog) |-> $past(win_cnt) == '1); // R2

  AST_NO_WRAP: assert property (@(posedge if_clk) disable iff (!if_rst_n)
    (&if_cnt && !if_bnd) |=> &if_cnt); // R4

  AST_HOLD_VALUE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !upd_pulse |=> $stable(freq_ratio)); // R5
endmodule

bind clk_ratio_meter clk_ratio_meter_chk #(.RES_W(RES_W), .CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2)) u_chk (.*);

// File: tb/clk_ratio_meter_test.sv
`timescale 1ps/1ps
module clk_ratio_meter_test;
  localparam int REF_T    = 40000;
  localparam int WIN_LOG2 = 10;
  localparam int INT_W    = 4;
  localparam int RES_W    = INT_W + 16;
  localparam int SHIFT    = 16 - WIN_LOG2;
  localparam int CNT_W    = RES_W - SHIFT;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam logic [31:0] RATIO = 32'h0000_0004;

  logic ref_clk = 1'b0;
  logic if_clk  = 1'b0;
  logic rst_n   = 1'b0;
  logic if_run  = 1'b1;
  int   if_half = 5000;
  logic [RES_W-1:0] freq_ratio;
  logic [31:0]      clk_ratio;

  int checks = 0;
  int fails  = 0;
  int ref_cycles = 0;
  bit done = 0;

  clk_ratio_meter #(.WIN_LOG2(WIN_LOG2), .INT_W(INT_W), .CLK_RATIO(RATIO)) uut (
    .ref_clk(ref_clk), .if_clk(if_clk), .rst_n(rst_n),
    .freq_ratio(freq_ratio), .clk_ratio(clk_ratio)
  );

  always #(REF_T/2) ref_clk = ~ref_clk;
  initial forever begin
    if (if_run) begin #(if_half); if_clk = ~if_clk; end
    else #1000;
  end

  function automatic longint exp_value(input int half);
    longint cnt;
    cnt = (longint'(WIN) * REF_T + half) / (2 * half);
    if (cnt >= (longint'(1) << CNT_W) - 1) return (longint'(1) << RES_W) - 1;
    return cnt << SHIFT;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check_rate(input string req);
    longint e, a, d;
    e = exp_value(if_half);
    a = longint'(freq_ratio);
    d = (a > e) ? a - e : e - a;
    check(d <= longint'(2) << SHIFT, req, a, e);
  endtask

  always @(posedge ref_clk) begin
    ref_cycles++;
    if (ref_cycles > 190000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", ref_cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_val;
    int changes;
    logic [RES_W-1:0] prev, held;
    seed_val = $urandom(32'h5eed);
    wait_ref(5);
    check(freq_ratio == '0, "R1", freq_ratio, 0);
    check(clk_ratio == RATIO, "R7", clk_ratio, RATIO);
    rst_n = 1'b1;
    wait_ref(1);
    check(freq_ratio == '0, "R1", freq_ratio, 0);
    // partial first window must not be reported (boundaries at 1024, 2048)
    wait_ref(1500);
    check(freq_ratio == '0, "R6", freq_ratio, 0);
    wait_ref(500);
    check(freq_ratio == '0, "R6", freq_ratio, 0);
    wait_ref(200);
    check_rate("R2 R3 ratio 4");
    check(clk_ratio == RATIO, "R7", clk_ratio, RATIO);

    for (int i = 0; i < 8; i++) begin
      if_half = 1300 + int'($urandom % 58700);
      wait_ref(3 * WIN + 100);
      check_rate("R3 random rate");
      if (i < 3) begin
        changes = 0;
        prev = freq_ratio;
        for (int k = 0; k < 2 * WIN; k++) begin
          wait_ref(1);
          if (freq_ratio != prev) changes++;
          prev = freq_ratio;
        end
        check(changes <= 3, "R5 updates per window", changes, 3);
      end
    end

    if_half = 20000;
    wait_ref(3 * WIN + 100);
    check_rate("R3 equal clocks");
    check(freq_ratio[RES_W-1:16] == 1, "R3 unity integer", freq_ratio, 32'h10000);

    if_half = 1000;
    wait_ref(3 * WIN + 100);
    check(&freq_ratio, "R4 saturate", freq_ratio, (longint'(1) << RES_W) - 1);

    if_half = 8000;
    wait_ref(3 * WIN + 100);
    check_rate("R3 after saturation");

    if_run = 1'b0;
    wait_ref(WIN);
    held = freq_ratio;
    wait_ref(3 * WIN);
    check(freq_ratio == held, "R5 stopped clock holds", freq_ratio, held);

    if_half = 30000;
    if_run = 1'b1;
    wait_ref(3 * WIN + 100);
    check_rate("R8 restart recovery");

    rst_n = 1'b0;
    wait_ref(2);
    check(freq_ratio == '0, "R1 reapplied", freq_ratio, 0);
    check(clk_ratio == RATIO, "R7 in reset", clk_ratio, RATIO);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule